// File: doc/BRIEF.md
# USB Buffer-Descriptor Token Engine

This block services a single USB token on an endpoint by consulting a buffer descriptor table held in system memory. The token is given as an endpoint number, a token code and a host/device mode bit. From these the block works out the transfer direction and picks one of two ping-pong descriptors for that endpoint and direction. It builds the descriptor address from three software page values, the endpoint, the direction bit and the ping-pong bit, and then reads the descriptor through a simple memory-master port.

If the descriptor belongs to the engine, the block copies packet bytes between a byte stream and the buffer that the descriptor points to. It then writes the descriptor back, updates the ping-pong bit and raises a sticky completion flag. If the descriptor belongs to software, the block ends the token with a busy (NAK-style) pulse and touches nothing else. A per-endpoint maximum packet size limits how much received data reaches memory. An overrun flag records both oversize packets and receive-FIFO overflows reported from outside.

The descriptor is two 32-bit words. Word 0 carries the ownership bit at bit 31, the keep bit at bit 30, software bits at 29:10 and the byte count at 9:0. Word 1, at descriptor address + 4, is the buffer byte address.

Top module: `usb_bd_engine`

## Requirements
- R1: The first access of each token is a word read at address {page_hi[7:0], page_mid[7:0], page_lo[6:0], endpoint[3:0], tx, odd, 3'b000}. Bits 31:24 come from page_hi, 23:16 from page_mid, 15:9 from page_lo, 8:5 from the endpoint, bit 4 is tx and bit 3 is odd.
- R2: Token codes are 00 OUT, 01 IN, 10 SETUP and 11 treated like OUT. tx is 1 for IN in device mode and for OUT/SETUP in host mode. Otherwise tx is 0, which means a receive.
- R3: Each endpoint and direction has its own odd bit, reset to 0. The bit flips only when a token on that endpoint and direction completes with tok_done. A NAKed token leaves it unchanged.
- R4: If word 0 bit 31 (ownership) is 0, the block pulses tok_nak for one cycle. It makes no further memory access, leaves the descriptor and done_flag unchanged and streams no data.
- R5: On a transmit, the block reads byte-count bytes from consecutive buffer addresses and presents them on tx_data in order. tx_last marks the final byte. A count of 0 sends nothing.
- R6: On a receive, accepted bytes are written one by one to consecutive buffer addresses. The written-back byte count equals the number of bytes stored.
- R7: On write-back, bit 31 is cleared unless keep (bit 30) is 1. Bits 30:10 are preserved. A transmit keeps its byte count.
- R8: Each serviced token produces a one-cycle tok_done pulse and sets done_flag. done_flag stays set until done_clr is asserted.
- R9: A completion that arrives while done_flag is already set (and not being cleared) also sets lost_flag. done_clr clears lost_flag.
- R10: Received bytes beyond the endpoint's maximum packet size (10 bits, reset 64, written through mps_we) are accepted from the stream but not written to memory. They set ovr_flag, and the byte count is written back equal to the limit.
- R11: rx_ovf high in any cycle sets ovr_flag. ovr_clr clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host, 0 = device |
| tok_valid | input | 1 | Token start, sampled while idle |
| tok_ep | input | 4 | Token endpoint |
| tok_pid | input | 2 | Token code |
| tok_done | output | 1 | Serviced-token pulse |
| tok_nak | output | 1 | Busy-descriptor pulse |
| page_hi | input | 8 | Table page, address bits 31:24 |
| page_mid | input | 8 | Table page, address bits 23:16 |
| page_lo | input | 7 | Table page, address bits 15:9 |
| mps_we | input | 1 | Max packet size write strobe |
| mps_ep | input | 4 | Endpoint written |
| mps_val | input | 10 | Max packet size value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_byte | output | 1 | 1 = byte access (data in bits 7:0), 0 = word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, byte in 7:0 for byte reads |
| mem_ack | input | 1 | Access completes this cycle |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte taken |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final receive byte |
| rx_ovf | input | 1 | Receive FIFO overflow event |
| done_clr | input | 1 | Clear done_flag and lost_flag |
| ovr_clr | input | 1 | Clear ovr_flag |
| done_flag | output | 1 | Sticky completion flag |
| lost_flag | output | 1 | Completion arrived while done_flag set |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench targets the address bits that are easy to mix up. It uses distinct page values in every field and endpoints whose tx bit differs between host and device mode, so a swapped direction table or a shifted field shows up as a wrong first address. It repeats a token on one endpoint and follows it with a NAKed token. That exposes a ping-pong bit that never toggles, or one that toggles on a busy descriptor, which would make the later token read the wrong descriptor. It also drives an oversize packet against a small limit and places a sentinel word just past the limit. A design that keeps writing would corrupt the sentinel or report the full count. A transmit with a zero byte count checks that no spurious byte is streamed.

// File: rtl/usb_bd_pkg.sv
package usb_bd_pkg;
  localparam int EP_W    = 4;
  localparam int NUM_EP  = 1 << EP_W;
  localparam int BC_W    = 10;
  localparam int AW      = 32;
  localparam int OWN_BIT = 31;
  localparam int KEEP_BIT = 30;

  typedef enum logic [1:0] {
    PID_OUT   = 2'b00,
    PID_IN    = 2'b01,
    PID_SETUP = 2'b10,
    PID_RSV   = 2'b11
  } pid_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_TXRD, S_TXOUT,
    S_RXWAIT, S_RXWR, S_WB, S_DONE, S_NAK
  } st_e;
endpackage

// File: rtl/bd_addr_gen.sv
module bd_addr_gen
  import usb_bd_pkg::*;
(
  input  logic            host_mode,
  input  logic [1:0]      pid,
  input  logic [EP_W-1:0] ep,
  input  logic            odd,
  input  logic [7:0]      page_hi,
  input  logic [7:0]      page_mid,
  input  logic [6:0]      page_lo,
  output logic            is_tx,
  output logic [AW-1:0]   bd_addr
);
  always_comb begin
    is_tx   = host_mode ^ (pid == PID_IN);
    bd_addr = {page_hi, page_mid, page_lo, ep, is_tx, odd, 3'b000};
  end
endmodule

// File: rtl/bd_pingpong.sv
module bd_pingpong
  import usb_bd_pkg::*;
#(
  parameter int NEP = NUM_EP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EP_W-1:0] rd_ep,
  input  logic            rd_tx,
  output logic            rd_odd,
  input  logic            upd,
  input  logic [EP_W-1:0] upd_ep,
  input  logic            upd_tx
);
  localparam int NBITS = 2 * NEP;

  logic [NBITS-1:0] odd_q, odd_d;

  always_comb begin
    odd_d = odd_q;
    if (upd) odd_d[{upd_ep, upd_tx}] = ~odd_q[{upd_ep, upd_tx}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odd_q <= '0;
    else        odd_q <= odd_d;
  end

  assign rd_odd = odd_q[{rd_ep, rd_tx}];

  // R3: the ping-pong bits only move on a completion
  p_odd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(odd_q));
endmodule

// File: rtl/bd_status.sv
module bd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_done,
  input  logic done_clr,
  input  logic evt_ovr,
  input  logic ovr_clr,
  output logic done_flag,
  output logic lost_flag,
  output logic ovr_flag
);
  logic done_q, lost_q, ovr_q;
  logic done_d, lost_d, ovr_d;

  always_comb begin
    done_d = evt_done ? 1'b1 : (done_clr ? 1'b0 : done_q);
    if (evt_done && done_q && !done_clr) lost_d = 1'b1;
    else if (done_clr)                   lost_d = 1'b0;
    else                                 lost_d = lost_q;
    ovr_d = evt_ovr ? 1'b1 : (ovr_clr ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lost_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      lost_q <= lost_d;
      ovr_q  <= ovr_d;
    end
  end

  assign done_flag = done_q;
  assign lost_flag = lost_q;
  assign ovr_flag  = ovr_q;

  // R9: a lost event needs an unacknowledged completion before it
  p_lost_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(done_q));
  // R8: the completion flag is sticky
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !done_clr) |=> done_q);
endmodule

// File: rtl/usb_bd_engine.sv
module usb_bd_engine
  import usb_bd_pkg::*;
#(
  parameter int MPS_RST = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_mode,
  input  logic        tok_valid,
  input  logic [3:0]  tok_ep,
  input  logic [1:0]  tok_pid,
  output logic        tok_done,
  output logic        tok_nak,
  input  logic [7:0]  page_hi,
  input  logic [7:0]  page_mid,
  input  logic [6:0]  page_lo,
  input  logic        mps_we,
  input  logic [3:0]  mps_ep,
  input  logic [9:0]  mps_val,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_byte,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  input  logic        rx_ovf,
  input  logic        done_clr,
  input  logic        ovr_clr,
  output logic        done_flag,
  output logic        lost_flag,
  output logic        ovr_flag
);
  localparam int PAD_W = AW - BC_W;

  st_e              st_q, st_d;
  logic [EP_W-1:0]  ep_q, ep_d;
  logic             tx_q, tx_d;
  logic [AW-1:0]    bd_q, bd_d;
  logic [31:0]      w0_q, w0_d;
  logic [AW-1:0]    buf_q, buf_d;
  logic [BC_W-1:0]  cnt_q, cnt_d;
  logic [7:0]       byte_q, byte_d;
  logic             last_q, last_d;
  logic [BC_W-1:0]  mps_q [NUM_EP];

  logic             ag_tx, pp_odd, pp_upd, evt_done, evt_len;
  logic [AW-1:0]    ag_addr, data_addr;
  logic [BC_W-1:0]  cnt_inc, bc_wb, mps_cur;

  bd_addr_gen u_addr (
    .host_mode(host_mode), .pid(tok_pid), .ep(tok_ep), .odd(pp_odd),
    .page_hi(page_hi), .page_mid(page_mid), .page_lo(page_lo),
    .is_tx(ag_tx), .bd_addr(ag_addr)
  );

  bd_pingpong #(.NEP(NUM_EP)) u_pp (
    .clk(clk), .rst_n(rst_n), .rd_ep(tok_ep), .rd_tx(ag_tx), .rd_odd(pp_odd),
    .upd(pp_upd), .upd_ep(ep_q), .upd_tx(tx_q)
  );

  bd_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_done(evt_done), .done_clr(done_clr),
    .evt_ovr(evt_len | rx_ovf), .ovr_clr(ovr_clr),
    .done_flag(done_flag), .lost_flag(lost_flag), .ovr_flag(ovr_flag)
  );

  assign cnt_inc   = cnt_q + 1'b1;
  assign data_addr = buf_q + {{PAD_W{1'b0}}, cnt_q};
  assign mps_cur   = mps_q[ep_q];
  assign bc_wb     = tx_q ? w0_q[BC_W-1:0] : cnt_q;
  assign tx_data   = byte_q;
  assign tok_done  = (st_q == S_DONE);
  assign tok_nak   = (st_q == S_NAK);

  always_comb begin
    st_d = st_q;  ep_d = ep_q;  tx_d = tx_q;  bd_d = bd_q;
    w0_d = w0_q;  buf_d = buf_q; cnt_d = cnt_q;
    byte_d = byte_q; last_d = last_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_byte = 1'b0;
    mem_addr = bd_q; mem_wdata = '0;
    tx_valid = 1'b0; tx_last = 1'b0; rx_ready = 1'b0;
    evt_done = 1'b0; evt_len = 1'b0; pp_upd = 1'b0;
    unique case (st_q)
      S_IDLE: if (tok_valid) begin
        ep_d = tok_ep; tx_d = ag_tx; bd_d = ag_addr; st_d = S_RD0;
      end
      S_RD0: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          w0_d = mem_rdata;
          st_d = mem_rdata[OWN_BIT] ? S_RD1 : S_NAK;
        end
      end
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = bd_q | 32'd4;
        if (mem_ack) begin
          buf_d = mem_rdata;
          cnt_d = '0;
          if (!tx_q)                      st_d = S_RXWAIT;
          else if (w0_q[BC_W-1:0] == '0)  st_d = S_WB;
          else                            st_d = S_TXRD;
        end
      end
      S_TXRD: begin
        mem_req = 1'b1; mem_byte = 1'b1; mem_addr = data_addr;
        if (mem_ack) begin
          byte_d = mem_rdata[7:0];
          st_d   = S_TXOUT;
        end
      end
      S_TXOUT: begin
        tx_valid = 1'b1;
        tx_last  = (cnt_inc == w0_q[BC_W-1:0]);
        if (tx_ready) begin
          cnt_d = cnt_inc;
          st_d  = tx_last ? S_WB : S_TXRD;
        end
      end
      S_RXWAIT: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          byte_d = rx_data;
          last_d = rx_last;
          if (cnt_q < mps_cur) st_d = S_RXWR;
          else begin
            evt_len = 1'b1;
            if (rx_last) st_d = S_WB;
          end
        end
      end
      S_RXWR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_byte = 1'b1;
        mem_addr = data_addr; mem_wdata = {24'b0, byte_q};
        if (mem_ack) begin
          cnt_d = cnt_inc;
          st_d  = last_q ? S_WB : S_RXWAIT;
        end
      end
      S_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_wdata = {w0_q[KEEP_BIT], w0_q[KEEP_BIT:BC_W], bc_wb};
        if (mem_ack) st_d = S_DONE;
      end
      S_DONE: begin
        evt_done = 1'b1; pp_upd = 1'b1; st_d = S_IDLE;
      end
      S_NAK:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ep_q <= '0; tx_q <= 1'b0; bd_q <= '0;
      w0_q <= '0; buf_q <= '0; cnt_q <= '0; byte_q <= '0; last_q <= 1'b0;
    end else begin
      st_q <= st_d; ep_q <= ep_d; tx_q <= tx_d; bd_q <= bd_d;
      w0_q <= w0_d; buf_q <= buf_d; cnt_q <= cnt_d; byte_q <= byte_d; last_q <= last_d;
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_mps
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mps_q[g] <= BC_W'(MPS_RST);
      else if (mps_we && mps_ep == g)  mps_q[g] <= mps_val;
    end
  end

  // R1: descriptor fetch is 8-byte aligned
  p_desc_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD0 && mem_req) |-> (mem_addr[2:0] == 3'b000));
  // R4: no write ever happens for a descriptor the engine does not own
  p_nak_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> w0_q[OWN_BIT]);
  // R10: byte writes stay below the packet limit
  p_mps_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_byte) |-> (cnt_q < mps_cur));
  // R5: stream stops after the final byte
  p_txlast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last && tx_ready) |=> !tx_valid);
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tok_done |=> !tok_done);
endmodule

// File: tb/usb_bd_engine_test.sv
module usb_bd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_mode, tok_valid;
  logic [3:0]  tok_ep;
  logic [1:0]  tok_pid;
  logic        tok_done, tok_nak;
  logic [7:0]  page_hi, page_mid;
  logic [6:0]  page_lo;
  logic        mps_we;
  logic [3:0]  mps_ep;
  logic [9:0]  mps_val;
  logic        mem_req, mem_we, mem_byte, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic        rx_valid, rx_ready, rx_last, rx_ovf;
  logic [7:0]  rx_data;
  logic        done_clr, ovr_clr, done_flag, lost_flag, ovr_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_bd_engine uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_pid(tok_pid), .tok_done(tok_done), .tok_nak(tok_nak),
    .page_hi(page_hi), .page_mid(page_mid), .page_lo(page_lo),
    .mps_we(mps_we), .mps_ep(mps_ep), .mps_val(mps_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_ovf(rx_ovf), .done_clr(done_clr), .ovr_clr(ovr_clr),
    .done_flag(done_flag), .lost_flag(lost_flag), .ovr_flag(ovr_flag)
  );

  // memory model: single-cycle, 1 KB aliased
  logic [31:0] mem [256];
  logic [31:0] mword;
  assign mword     = mem[mem_addr[9:2]];
  assign mem_ack   = mem_req;
  assign mem_rdata = mem_byte ? (mword >> {mem_addr[1:0], 3'b000}) : mword;

  always @(posedge clk)
    if (mem_req && mem_we) begin
      if (mem_byte) mem[mem_addr[9:2]][{mem_addr[1:0], 3'b000} +: 8] <= mem_wdata[7:0];
      else          mem[mem_addr[9:2]] <= mem_wdata;
    end

  // access and transmit logs
  logic [31:0] log_addr [64];
  int          log_n = 0;
  logic [7:0]  tx_log [16];
  int          tx_n = 0;
  int          tx_last_idx = -1;

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      log_addr[log_n[5:0]] <= mem_addr;
      log_n <= log_n + 1;
    end
    if (tx_valid && tx_ready) begin
      tx_log[tx_n[3:0]] <= tx_data;
      if (tx_last) tx_last_idx <= tx_n;
      tx_n <= tx_n + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic token(input logic hm, input logic [3:0] ep, input logic [1:0] pid);
    @(negedge clk);
    host_mode = hm; tok_ep = ep; tok_pid = pid; tok_valid = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last);
    rx_valid = 1'b1; rx_data = d; rx_last = last;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_end(output logic got_done, output logic got_nak);
    got_done = 1'b0; got_nak = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (tok_done || tok_nak) begin
        got_done = tok_done; got_nak = tok_nak;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic pulse_done_clr();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8", "done_flag after reset", {31'b0, done_flag}, 32'd0);
    chk("R9", "lost_flag after reset", {31'b0, lost_flag}, 32'd0);
    chk("R11", "ovr_flag after reset", {31'b0, ovr_flag}, 32'd0);
    chk("R4", "mem_req idle", {31'b0, mem_req}, 32'd0);
  endtask

  // device OUT twice on endpoint 2: receive, ping-pong, lost event
  task automatic t_dev_out_pair();
    logic d, n;
    int n0;
    mem[16] = {1'b1, 1'b0, 20'h0F0F0, 10'd0}; mem[17] = 32'h200;
    mem[18] = {1'b1, 1'b0, 20'h00001, 10'd0}; mem[19] = 32'h240;
    mem[128] = 0; mem[129] = 0; mem[144] = 0;
    n0 = log_n;
    token(1'b0, 4'd2, 2'b00);
    send_byte(8'hA1, 0); send_byte(8'hA2, 0); send_byte(8'hA3, 0);
    send_byte(8'hA4, 0); send_byte(8'hA5, 1);
    wait_end(d, n);
    chk("R1", "first address dev OUT ep2 odd0", log_addr[n0[5:0]], 32'hA53C_0040);
    chk("R8", "tok_done pulse", {31'b0, d}, 32'd1);
    chk("R6", "rx buffer word 0", mem[128], 32'hA4A3_A2A1);
    chk("R6", "rx buffer word 1", mem[129], 32'h0000_00A5);
    chk("R7", "write-back clears own, count 5", mem[16], {1'b0, 1'b0, 20'h0F0F0, 10'd5});
    chk("R8", "done_flag set", {31'b0, done_flag}, 32'd1);
    chk("R9", "no lost on first completion", {31'b0, lost_flag}, 32'd0);
    n0 = log_n;
    token(1'b0, 4'd2, 2'b10 ^ 2'b10);
    send_byte(8'hB1, 0); send_byte(8'hB2, 1);
    wait_end(d, n);
    chk("R3", "second token uses odd buffer", log_addr[n0[5:0]], 32'hA53C_0048);
    chk("R6", "odd buffer data", mem[144], 32'h0000_B2B1);
    chk("R7", "odd descriptor write-back", mem[18], {1'b0, 1'b0, 20'h00001, 10'd2});
    chk("R9", "lost_flag on unacked completion", {31'b0, lost_flag}, 32'd1);
    pulse_done_clr();
    chk("R8", "done_flag cleared", {31'b0, done_flag}, 32'd0);
    chk("R9", "lost_flag cleared", {31'b0, lost_flag}, 32'd0);
  endtask

  // device IN on endpoint 1 with keep set
  task automatic t_dev_in_keep();
    logic d, n;
    int n0, t0;
    mem[12] = {1'b1, 1'b1, 20'h0ABCD, 10'd3}; mem[13] = 32'h280;
    mem[160] = 32'h4433_2211;
    n0 = log_n; t0 = tx_n;
    token(1'b0, 4'd1, 2'b01);
    wait_end(d, n);
    chk("R2", "device IN is transmit (bit4=1)", log_addr[n0[5:0]], 32'hA53C_0030);
    chk("R5", "tx byte count", tx_n - t0, 32'd3);
    chk("R5", "tx byte 0", {24'b0, tx_log[t0[3:0]]}, 32'h11);
    chk("R5", "tx byte 1", {24'b0, tx_log[4'(t0 + 1)]}, 32'h22);
    chk("R5", "tx byte 2", {24'b0, tx_log[4'(t0 + 2)]}, 32'h33);
    chk("R5", "tx_last on final byte", tx_last_idx, t0 + 2);
    chk("R7", "keep holds own, count kept", mem[12], {1'b1, 1'b1, 20'h0ABCD, 10'd3});
    pulse_done_clr();
  endtask

  // host mode: IN is receive, OUT is transmit (zero length)
  task automatic t_host();
    logic d, n;
    int n0, t0;
    mem[24] = 32'h8000_0000; mem[25] = 32'h300; mem[192] = 0;
    mem[28] = 32'h8000_0000; mem[29] = 32'h320;
    n0 = log_n;
    token(1'b1, 4'd3, 2'b01);
    send_byte(8'hC1, 0); send_byte(8'hC2, 1);
    wait_end(d, n);
    chk("R2", "host IN is receive (bit4=0)", log_addr[n0[5:0]], 32'hA53C_0060);
    chk("R6", "host IN data", mem[192], 32'h0000_C2C1);
    n0 = log_n; t0 = tx_n;
    token(1'b1, 4'd3, 2'b00);
    wait_end(d, n);
    chk("R2", "host OUT is transmit (bit4=1)", log_addr[n0[5:0]], 32'hA53C_0070);
    chk("R5", "zero-length transmit sends nothing", tx_n - t0, 32'd0);
    chk("R8", "zero-length completes", {31'b0, d}, 32'd1);
    chk("R7", "zero-length write-back", mem[28], 32'h0000_0000);
    pulse_done_clr();
  endtask

  // descriptor owned by software, then a serviced token on the same buffer
  task automatic t_nak();
    logic d, n;
    int n0;
    page_lo = 7'h55;
    mem[128] = 32'h0000_0007;
    n0 = log_n;
    token(1'b0, 4'd0, 2'b00);
    wait_end(d, n);
    chk("R4", "tok_nak pulse", {31'b0, n}, 32'd1);
    chk("R4", "no tok_done on nak", {31'b0, d}, 32'd0);
    chk("R1", "page_lo in bits 15:9", log_addr[n0[5:0]], 32'hA53C_AA00);
    chk("R4", "single access on nak", log_n - n0, 32'd1);
    chk("R4", "descriptor untouched", mem[128], 32'h0000_0007);
    chk("R4", "done_flag unchanged", {31'b0, done_flag}, 32'd0);
    page_lo = 7'h00;
    mem[0] = 32'h8000_0000; mem[1] = 32'h340; mem[208] = 0;
    n0 = log_n;
    token(1'b0, 4'd0, 2'b00);
    send_byte(8'hD1, 1);
    wait_end(d, n);
    chk("R3", "odd unchanged after nak", log_addr[n0[5:0]], 32'hA53C_0000);
    chk("R6", "single byte stored", mem[208], 32'h0000_00D1);
    pulse_done_clr();
  endtask

  // oversize packet, then external FIFO overflow
  task automatic t_overrun();
    logic d, n;
    @(negedge clk); mps_we = 1'b1; mps_ep = 4'd4; mps_val = 10'd4;
    @(negedge clk); mps_we = 1'b0;
    mem[32] = 32'hC000_0000; mem[33] = 32'h380;
    mem[224] = 0; mem[225] = 32'hDEAD_BEEF;
    token(1'b0, 4'd4, 2'b00);
    for (int i = 1; i <= 6; i++) send_byte(8'(i), i == 6);
    wait_end(d, n);
    chk("R10", "bytes within limit", mem[224], 32'h0403_0201);
    chk("R10", "sentinel past limit", mem[225], 32'hDEAD_BEEF);
    chk("R10", "count capped, keep holds own", mem[32], 32'hC000_0004);
    chk("R10", "ovr_flag set", {31'b0, ovr_flag}, 32'd1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk("R11", "ovr_flag cleared", {31'b0, ovr_flag}, 32'd0);
    rx_ovf = 1'b1;
    @(negedge clk); rx_ovf = 1'b0;
    chk("R11", "fifo overflow sets ovr_flag", {31'b0, ovr_flag}, 32'd1);
    pulse_done_clr();
  endtask

  // device SETUP is a receive
  task automatic t_setup();
    logic d, n;
    int n0;
    mem[40] = 32'h8000_0000; mem[41] = 32'h3C0; mem[240] = 0;
    n0 = log_n;
    token(1'b0, 4'd5, 2'b10);
    send_byte(8'hE1, 1);
    wait_end(d, n);
    chk("R2", "device SETUP is receive", log_addr[n0[5:0]], 32'hA53C_00A0);
    chk("R6", "setup byte stored", mem[240], 32'h0000_00E1);
    pulse_done_clr();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 1'b0; host_mode = 1'b0; tok_valid = 1'b0; tok_ep = '0; tok_pid = '0;
    page_hi = 8'hA5; page_mid = 8'h3C; page_lo = 7'h00;
    mps_we = 1'b0; mps_ep = '0; mps_val = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_ovf = 1'b0;
    done_clr = 1'b0; ovr_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dev_out_pair();
    t_dev_in_keep();
    t_host();
    t_nak();
    t_overrun();
    t_setup();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule